// File: doc/BRIEF.md
# Frequency Steering and Lock Indicator

This block watches two divided-down clock event streams inside one system clock domain. One is a reference strobe and the other is a feedback strobe. Each stream is a single-cycle pulse for each rising edge of its divided clock. The block does not measure phase in analog form. It reports how the two streams are ordered in time, using three signals.

The first signal is a charge window. It opens when a reference event arrives and closes when the next feedback event arrives, so its width follows the phase lead of the reference.

The second signal is a steering output modelled as a three-state pin, made of an enable and a level. It fires only when one stream delivers two events in a row with no event from the other stream between them. A high level means the feedback stream is too slow. A low level means it is too fast. The pulses therefore repeat at about the beat frequency between the two inputs. The third signal is a lock flag, which drops for exactly the cycles in which a steering pulse is driven.

Top module: `fsl_lock_steer`

## Requirements
- R1: A reference strobe that arrives without a feedback strobe sets `charge` high on the next clock edge. `charge` then stays high while no strobe arrives.
- R2: A feedback strobe clears `charge` on the next clock edge. This includes a feedback strobe that arrives in the same cycle as a reference strobe.
- R3: When a reference strobe arrives alone and the most recent earlier event was also a reference-only strobe, the next cycle drives `steer_oe`=1 with `steer_level`=1.
- R4: When a feedback strobe arrives alone and the most recent earlier event was also a feedback-only strobe, the next cycle drives `steer_oe`=1 with `steer_level`=0.
- R5: A steering pulse lasts exactly one clock cycle. In every cycle with `steer_oe`=0, `steer_level` reads 0, so the pin is high-impedance.
- R6: `lock` is the inverse of `steer_oe` in every cycle.
- R7: A cycle in which both strobes arrive produces no steering pulse. It also forgets the order history, so the next single strobe of either kind produces no pulse.
- R8: A cycle with `rst`=1 clears `charge`, sets `steer_oe` to 0 and `lock` to 1, and forgets the order history, whatever the strobes do in that cycle. Reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Reference event strobe, one cycle per divided reference edge |
| fb_stb | input | 1 | Feedback event strobe, one cycle per divided feedback edge |
| charge | output | 1 | Ramp-charge window, from reference event to feedback event |
| steer_oe | output | 1 | Steering output enable; 0 means high-impedance |
| steer_level | output | 1 | Steering level when enabled: 1 means speed up, 0 means slow down |
| lock | output | 1 | High while locked, low during steering pulses |

## Verification
The hardest cases to reach from the ports are the ones where the history register alone decides the outcome. One case is a lone strobe that follows a coincident pair. Another is a repeated strobe that follows a reset applied while a strobe was active. The bench covers both by sweeping every sequence of five strobe symbols (none, reference, feedback, both). Before each sequence it applies a reset with a reference strobe held high. It checks every output in every cycle against an arithmetic order model.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [1:0] {LAST_NONE = 2'd0, LAST_REF = 2'd1, LAST_FB = 2'd2} last_e;
  typedef enum logic [1:0] {STEER_IDLE = 2'd0, STEER_UP = 2'd1, STEER_DOWN = 2'd2} steer_e;

  // Pulse decision from the previous event and the current strobes.
  function automatic steer_e steer_decide(last_e prev, logic r, logic v);
    steer_e d;
    d = STEER_IDLE;
    if (r && !v && prev == LAST_REF) d = STEER_UP;
    if (v && !r && prev == LAST_FB)  d = STEER_DOWN;
    return d;
  endfunction

  // History update: a coincident pair erases the order.
  function automatic last_e last_update(last_e prev, logic r, logic v);
    last_e n;
    n = prev;
    if (r && v)      n = LAST_NONE;
    else if (r)      n = LAST_REF;
    else if (v)      n = LAST_FB;
    return n;
  endfunction
endpackage

// File: rtl/fsl_edge_order.sv
module fsl_edge_order
  import fsl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ref_stb,
  input  logic   fb_stb,
  output steer_e decision
);
  last_e last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= LAST_NONE;
    else     last_q <= last_update(last_q, ref_stb, fb_stb);
  end

  assign decision = rst ? STEER_IDLE : steer_decide(last_q, ref_stb, fb_stb);
endmodule

// File: rtl/fsl_charge_window.sv
module fsl_charge_window (
  input  logic clk,
  input  logic rst,
  input  logic ref_stb,
  input  logic fb_stb,
  output logic charge
);
  always_ff @(posedge clk) begin
    if (rst || fb_stb) charge <= 1'b0;
    else if (ref_stb)  charge <= 1'b1;
  end
endmodule

// File: rtl/fsl_steer_drive.sv
module fsl_steer_drive
  import fsl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  steer_e decision,
  output logic   steer_oe,
  output logic   steer_level,
  output logic   lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      steer_oe    <= 1'b0;
      steer_level <= 1'b0;
      lock        <= 1'b1;
    end else begin
      steer_oe    <= (decision != STEER_IDLE);
      steer_level <= (decision == STEER_UP);
      lock        <= (decision == STEER_IDLE);
    end
  end
endmodule

// File: rtl/fsl_lock_steer.sv
module fsl_lock_steer
  import fsl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_stb,
  input  logic fb_stb,
  output logic charge,
  output logic steer_oe,
  output logic steer_level,
  output logic lock
);
  steer_e decision;
  logic   up_evt;
  logic   down_evt;

  fsl_edge_order u_order (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb), .decision(decision)
  );

  fsl_charge_window u_charge (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb), .charge(charge)
  );

  fsl_steer_drive u_drive (
    .clk(clk), .rst(rst), .decision(decision),
    .steer_oe(steer_oe), .steer_level(steer_level), .lock(lock)
  );

  assign up_evt   = (decision == STEER_UP);
  assign down_evt = (decision == STEER_DOWN);
endmodule

// File: rtl/fsl_lock_steer_chk.sv
module fsl_lock_steer_chk (
  input logic clk,
  input logic rst,
  input logic ref_stb,
  input logic fb_stb,
  input logic charge,
  input logic steer_oe,
  input logic steer_level,
  input logic lock,
  input logic up_evt,
  input logic down_evt
);
  assert_charge_open_R1: assert property (@(posedge clk) disable iff (rst)
    (ref_stb && !fb_stb) |=> charge);

  assert_charge_close_R2: assert property (@(posedge clk) disable iff (rst)
    fb_stb |=> !charge);

  assert_up_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    up_evt |=> (steer_oe && steer_level));

  assert_down_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    down_evt |=> (steer_oe && !steer_level));

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (steer_oe && !up_evt && !down_evt) |=> !steer_oe);

  assert_hiz_level_R5: assert property (@(posedge clk) disable iff (rst)
    !steer_oe |-> !steer_level);

  assert_lock_inverse_R6: assert property (@(posedge clk) disable iff (rst)
    lock != steer_oe);

  assert_both_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (ref_stb && fb_stb) |=> !steer_oe);
endmodule

bind fsl_lock_steer fsl_lock_steer_chk u_chk (.*);

// File: tb/tb_fsl_lock_steer.sv
module tb_fsl_lock_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_stb = 1'b0;
  logic fb_stb = 1'b0;
  logic charge, steer_oe, steer_level, lock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Order model: 0 none, 1 reference, 2 feedback.
  int m_last;
  bit m_charge, m_oe, m_lvl;

  always #5 clk = ~clk;

  fsl_lock_steer dut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .charge(charge), .steer_oe(steer_oe), .steer_level(steer_level), .lock(lock)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(bit r, bit v);
    int code;
    code = 2 * int'(v) + int'(r);   // 1 ref only, 2 fb only, 3 both
    m_oe  = 0;
    m_lvl = 0;
    case (code)
      1: begin m_oe = (m_last == 1); m_lvl = m_oe; m_charge = 1; m_last = 1; end
      2: begin m_oe = (m_last == 2); m_charge = 0; m_last = 2; end
      3: begin m_charge = 0; m_last = 0; end
      default: ;
    endcase
  endtask

  task automatic check_all();
    check("R1/R2 charge", charge, m_charge);
    check(m_lvl ? "R3 steer_oe" : "R4 steer_oe", steer_oe, m_oe);
    check("R5 steer_level", steer_level, m_lvl);
    check("R6 lock", lock, !m_oe);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int s = 0; s < 1024; s++) begin
      // R8: reset wins over an active reference strobe.
      rst = 1; ref_stb = 1; fb_stb = (s[0] == 1'b1);
      @(negedge clk);
      m_last = 0; m_charge = 0; m_oe = 0; m_lvl = 0;
      check("R8 charge", charge, 1'b0);
      check("R8 steer_oe", steer_oe, 1'b0);
      check("R8 lock", lock, 1'b1);
      rst = 0;
      for (int k = 0; k < 5; k++) begin
        int sym;
        sym = (s >> (2 * k)) & 3;
        ref_stb = sym[0];
        fb_stb  = sym[1];
        @(negedge clk);
        model_step(sym[0], sym[1]);
        if (sym == 3) check("R7 no pulse on coincident pair", steer_oe, 1'b0);
        check_all();
      end
      ref_stb = 0; fb_stb = 0;
      @(negedge clk);
      model_step(0, 0);
      check("R5 pulse ends", steer_oe, 1'b0);
      check_all();
    end
    // R1: charge holds across idle cycles.
    rst = 1; @(negedge clk); rst = 0;
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R1 charge hold", charge, 1'b1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule